// File: doc/BRIEF.md
# Correctable ECC Error Status Tracker

This block sits beside the read datapath of a memory protected by ECC. It listens to single-bit correction reports from two read ports and keeps sticky status for software. Port 2 reports come with the failing address, the bit position and the value the bit should have held. Each port 2 report is sorted by polarity: a stored one read back as zero is a one-fail, and a stored zero read back as one is a zero-fail. Each polarity has its own enable. Port 1 reports carry only an address. Any of them counts as a zero-fail while either enable is set.

Every qualifying error sets flags and captures the failing address. A port 2 error also captures the bit position. The block then raises a one-cycle event pulse. A profiling counter totals the qualifying errors while profiling is enabled, and sets a flag once the total reaches a programmable threshold. Software uses a small write port to set the enables, the threshold and the counter value, and to clear flags.

Top module: `ecc_err_tracker`

## Requirements
- R1: After reset, all four flags, the captured address, the captured position, the counter and the event output are zero.
- R2: A port 2 error with expected bit 1, while the one-fail enable (control bit 0) is set, sets the one-fail flag and the port 2 flag. It also captures the port 2 address and bit position. The flags are visible after the next clock edge.
- R3: A port 2 error with expected bit 0, while the zero-fail enable (control bit 1) is set, sets the zero-fail flag and the port 2 flag, and captures the address and position.
- R4: A port 2 error whose polarity enable is clear changes no flag, capture, counter or event.
- R5: A port 1 error sets only the zero-fail flag and captures only the address, provided either enable is set. It leaves the position unchanged. With both enables clear it has no effect.
- R6: The event output is high for exactly the one cycle after each cycle that holds at least one qualifying error. Two errors in the same cycle give one pulse.
- R7: A write to address 2 clears each flag whose data bit is 1. The bits are [0] one-fail, [1] zero-fail, [2] port 2 and [3] profiling. A new error in the same cycle keeps its flag set.
- R8: While profiling (control bit 2) is enabled, the counter adds 1 for each qualifying error, or 2 when both ports qualify in the same cycle. It saturates at its all-ones value.
- R9: The profiling flag sets when a counted error brings the counter to or past the threshold (address 1). Once profiling is disabled, the flag and the counter read zero from the second edge after the control write.
- R10: A write to address 3 loads the counter with the write data.
- R11: When both ports qualify in the same cycle, the port 2 address and position are captured, and both ports' flags are set.
- R12: Writes to address 0 set the control bits. They apply to errors from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p1_err_vld | input | 1 | Port 1 correctable-error strobe |
| p1_err_addr | input | AW | Port 1 failing address |
| p2_err_vld | input | 1 | Port 2 correctable-error strobe |
| p2_err_addr | input | AW | Port 2 failing address |
| p2_err_pos | input | PW | Port 2 failing bit position |
| p2_exp_bit | input | 1 | Value the port 2 bit should have held |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 threshold, 2 clear, 3 counter |
| reg_wdata | input | CW | Register write data |
| flg_one | output | 1 | Sticky one-fail flag |
| flg_zero | output | 1 | Sticky zero-fail flag |
| flg_p2 | output | 1 | Sticky port 2 correctable-error flag |
| flg_prof | output | 1 | Sticky profiling threshold flag |
| cap_addr | output | AW | Last captured failing address |
| cap_pos | output | PW | Last captured port 2 bit position |
| err_event | output | 1 | One-cycle error event pulse |
| prof_count | output | CW | Profiling counter |

## Verification
A table of single-cycle error patterns is walked under each combination of the enables. It covers port 2 errors of both polarities with the matching enable and with the other one, port 1 errors under each enable and under none, and both ports at once with port 2 qualified or not. These patterns separate a polarity that was decoded wrongly from an enable that was ignored, and a port 1 error that writes the position from a priority that was inverted. Directed tests then cover the single-cycle event, partial clears and a clear that meets a new error, the threshold crossing, the clear on disable, counter load and saturation.

// File: rtl/ecc_trk_pkg.sv
package ecc_trk_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_THR  = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

  localparam int F_ONE  = 0;
  localparam int F_ZERO = 1;
  localparam int F_P2   = 2;
  localparam int NFLAG  = 3;

  typedef struct packed {
    logic p1;
    logic p2_one;
    logic p2_zero;
  } qual_t;
endpackage

// File: rtl/ecc_trk_classify.sv
module ecc_trk_classify
  import ecc_trk_pkg::*;
(
  input  logic  en_one,
  input  logic  en_zero,
  input  logic  p1_vld,
  input  logic  p2_vld,
  input  logic  p2_exp,
  output qual_t q
);
  always_comb begin
    q.p2_one  = p2_vld &&  p2_exp && en_one;
    q.p2_zero = p2_vld && !p2_exp && en_zero;
    q.p1      = p1_vld && (en_one || en_zero);
  end
endmodule

// File: rtl/ecc_trk_flags.sv
module ecc_trk_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flg
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic d;
    logic q;
    always_comb d = set[i] || (q && !clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flg[i] = q;
  end
endmodule

// File: rtl/ecc_trk_profile.sv
module ecc_trk_profile #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    inc,
  input  logic [CW-1:0] thr,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          clr_flag,
  output logic [CW-1:0] cnt,
  output logic          flag
);
  logic [CW:0]   sum;
  logic [CW-1:0] sat;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;
  logic          flag_d;
  logic          flag_q;

  always_comb begin
    sum = {1'b0, cnt_q} + (CW+1)'(inc);
    sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    if (!en)     cnt_d = '0;
    else if (ld) cnt_d = ld_val;
    else         cnt_d = sat;
    flag_d = en && ((flag_q && !clr_flag) || ((inc != 2'd0) && (sat >= thr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/ecc_err_tracker.sv
module ecc_err_tracker
  import ecc_trk_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p1_err_vld,
  input  logic [AW-1:0] p1_err_addr,
  input  logic          p2_err_vld,
  input  logic [AW-1:0] p2_err_addr,
  input  logic [PW-1:0] p2_err_pos,
  input  logic          p2_exp_bit,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic          flg_one,
  output logic          flg_zero,
  output logic          flg_p2,
  output logic          flg_prof,
  output logic [AW-1:0] cap_addr,
  output logic [PW-1:0] cap_pos,
  output logic          err_event,
  output logic [CW-1:0] prof_count
);
  qual_t            q;
  logic [2:0]       ctl_d, ctl_q;
  logic [CW-1:0]    thr_d, thr_q;
  logic [AW-1:0]    addr_d, addr_q;
  logic [PW-1:0]    pos_d, pos_q;
  logic             ev_d, ev_q;
  logic [NFLAG-1:0] fset, fclr, fout;
  logic             wr_clr, wr_cnt, p2q;
  logic [1:0]       inc;

  ecc_trk_classify u_cls (
    .en_one (ctl_q[0]),
    .en_zero(ctl_q[1]),
    .p1_vld (p1_err_vld),
    .p2_vld (p2_err_vld),
    .p2_exp (p2_exp_bit),
    .q      (q)
  );

  always_comb begin
    ctl_d  = ctl_q;
    thr_d  = thr_q;
    wr_clr = reg_we && (reg_addr == A_CLR);
    wr_cnt = reg_we && (reg_addr == A_CNT);
    if (reg_we && reg_addr == A_CTRL) ctl_d = reg_wdata[2:0];
    if (reg_we && reg_addr == A_THR)  thr_d = reg_wdata;
    p2q    = q.p2_one || q.p2_zero;
    fset[F_ONE]  = q.p2_one;
    fset[F_ZERO] = q.p2_zero || q.p1;
    fset[F_P2]   = p2q;
    fclr   = wr_clr ? reg_wdata[NFLAG-1:0] : '0;
    addr_d = addr_q;
    pos_d  = pos_q;
    if (p2q) begin
      addr_d = p2_err_addr;
      pos_d  = p2_err_pos;
    end else if (q.p1) begin
      addr_d = p1_err_addr;
    end
    inc  = {1'b0, q.p1} + {1'b0, p2q};
    ev_d = q.p1 || p2q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      thr_q  <= '0;
      addr_q <= '0;
      pos_q  <= '0;
      ev_q   <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      thr_q  <= thr_d;
      addr_q <= addr_d;
      pos_q  <= pos_d;
      ev_q   <= ev_d;
    end
  end

  ecc_trk_flags #(.N(NFLAG)) u_flg (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (fset),
    .clr  (fclr),
    .flg  (fout)
  );

  ecc_trk_profile #(.CW(CW)) u_prof (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_q[2]),
    .inc     (inc),
    .thr     (thr_q),
    .ld      (wr_cnt),
    .ld_val  (reg_wdata),
    .clr_flag(wr_clr && reg_wdata[NFLAG]),
    .cnt     (prof_count),
    .flag    (flg_prof)
  );

  assign flg_one   = fout[F_ONE];
  assign flg_zero  = fout[F_ZERO];
  assign flg_p2    = fout[F_P2];
  assign cap_addr  = addr_q;
  assign cap_pos   = pos_q;
  assign err_event = ev_q;
endmodule

// File: rtl/ecc_trk_chk.sv
module ecc_trk_chk #(
  parameter int PW = 7,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p1_err_vld,
  input logic          p2_err_vld,
  input logic          p2_exp_bit,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [2:0]    ctl_q,
  input logic          flg_one,
  input logic          flg_zero,
  input logic          flg_p2,
  input logic          flg_prof,
  input logic [PW-1:0] cap_pos,
  input logic          err_event,
  input logic [CW-1:0] prof_count
);
  // R2
  one_sets_p2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_one) |-> flg_p2);

  // R6
  event_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> (flg_one || flg_zero));

  // R5
  p1_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_err_vld && !p2_err_vld) |=> $stable(cap_pos));

  // R4
  p2_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_err_vld && !p1_err_vld && !(p2_exp_bit ? ctl_q[0] : ctl_q[1])) |=> !err_event);

  // R9
  prof_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[2] |=> !flg_prof);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_count == {CW{1'b1}} && ctl_q[2] && !(reg_we && reg_addr == 2'd3))
      |=> prof_count == {CW{1'b1}});
endmodule

bind ecc_err_tracker ecc_trk_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p1_err_vld(p1_err_vld),
  .p2_err_vld(p2_err_vld),
  .p2_exp_bit(p2_exp_bit),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ctl_q     (ctl_q),
  .flg_one   (flg_one),
  .flg_zero  (flg_zero),
  .flg_p2    (flg_p2),
  .flg_prof  (flg_prof),
  .cap_pos   (cap_pos),
  .err_event (err_event),
  .prof_count(prof_count)
);

// File: tb/sim_ecc_err_tracker.sv
module sim_ecc_err_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p1_err_vld = 1'b0;
  logic [15:0] p1_err_addr = '0;
  logic        p2_err_vld = 1'b0;
  logic [15:0] p2_err_addr = '0;
  logic [6:0]  p2_err_pos = '0;
  logic        p2_exp_bit = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        flg_one, flg_zero, flg_p2, flg_prof, err_event;
  logic [15:0] cap_addr;
  logic [6:0]  cap_pos;
  logic [7:0]  prof_count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc_err_tracker u0 (.*);

  typedef struct packed {
    logic [2:0]  ctl;
    logic        p1v;
    logic [15:0] p1a;
    logic        p2v;
    logic [15:0] p2a;
    logic [6:0]  pos;
    logic        exb;
    logic [2:0]  fl;   // [0] one, [1] zero, [2] port 2
    logic        ev;
    logic [1:0]  cnt;
    logic        na;
    logic [15:0] ea;
    logic        np;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'b101, 1'b0, 16'h0000, 1'b1, 16'h1234, 7'd5,  1'b1, 3'b101, 1'b1, 2'd1, 1'b1, 16'h1234, 1'b1}, // R2
    '{3'b110, 1'b0, 16'h0000, 1'b1, 16'h2222, 7'd9,  1'b0, 3'b110, 1'b1, 2'd1, 1'b1, 16'h2222, 1'b1}, // R3
    '{3'b110, 1'b0, 16'h0000, 1'b1, 16'h3333, 7'd11, 1'b1, 3'b000, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0}, // R4
    '{3'b101, 1'b0, 16'h0000, 1'b1, 16'h3434, 7'd12, 1'b0, 3'b000, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0}, // R4
    '{3'b101, 1'b1, 16'h4444, 1'b0, 16'h0000, 7'd0,  1'b0, 3'b010, 1'b1, 2'd1, 1'b1, 16'h4444, 1'b0}, // R5
    '{3'b110, 1'b1, 16'h5555, 1'b0, 16'h0000, 7'd0,  1'b0, 3'b010, 1'b1, 2'd1, 1'b1, 16'h5555, 1'b0}, // R5
    '{3'b100, 1'b1, 16'h5656, 1'b0, 16'h0000, 7'd0,  1'b0, 3'b000, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0}, // R5
    '{3'b111, 1'b1, 16'h6666, 1'b1, 16'h7777, 7'd3,  1'b1, 3'b111, 1'b1, 2'd2, 1'b1, 16'h7777, 1'b1}, // R11
    '{3'b101, 1'b1, 16'h1111, 1'b1, 16'h2020, 7'd4,  1'b0, 3'b010, 1'b1, 2'd1, 1'b1, 16'h1111, 1'b0}, // R11
    '{3'b011, 1'b0, 16'h0000, 1'b1, 16'hAAAA, 7'd7,  1'b1, 3'b101, 1'b1, 2'd0, 1'b1, 16'hAAAA, 1'b1}  // R9
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      7, 8: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic err(logic v1, logic [15:0] a1, logic v2, logic [15:0] a2,
                     logic [6:0] ps, logic eb);
    @(negedge clk);
    p1_err_vld = v1; p1_err_addr = a1;
    p2_err_vld = v2; p2_err_addr = a2; p2_err_pos = ps; p2_exp_bit = eb;
    @(posedge clk);
    @(negedge clk);
    p1_err_vld = 1'b0; p2_err_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa;
    logic [6:0]  pp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "flags", {flg_prof, flg_p2, flg_zero, flg_one}, 0);
    check("R1", "addr", cap_addr, 0);
    check("R1", "pos", cap_pos, 0);
    check("R1", "count", prof_count, 0);
    check("R1", "event", err_event, 0);

    wr(2'd1, 8'd200);
    for (int i = 0; i < NV; i++) begin
      // R12 control write ahead of each error
      wr(2'd0, {5'b0, VEC[i].ctl});
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'h00);
      pa = cap_addr; pp = cap_pos;
      err(VEC[i].p1v, VEC[i].p1a, VEC[i].p2v, VEC[i].p2a, VEC[i].pos, VEC[i].exb);
      check(vreq(i), "flags", {flg_p2, flg_zero, flg_one}, VEC[i].fl);
      check(vreq(i), "event", err_event, VEC[i].ev);
      check(vreq(i), "count", prof_count, VEC[i].cnt);
      check(vreq(i), "addr", cap_addr, VEC[i].na ? VEC[i].ea : pa);
      check(vreq(i), "pos", cap_pos, VEC[i].np ? VEC[i].pos : pp);
    end

    // R6 single pulse: event drops the cycle after
    @(negedge clk);
    check("R6", "event low", err_event, 0);

    // R7 partial clear and clear-vs-set
    wr(2'd0, 8'h03);
    err(1'b0, 0, 1'b1, 16'h0101, 7'd1, 1'b1);
    wr(2'd2, 8'h01);
    check("R7", "flags after bit0 clear", {flg_p2, flg_zero, flg_one}, 3'b100);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    p2_err_vld = 1'b1; p2_err_addr = 16'h0202; p2_exp_bit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; p2_err_vld = 1'b0;
    check("R7", "set wins over clear", flg_one, 1);

    // R9 threshold crossing
    wr(2'd0, 8'h05);
    wr(2'd1, 8'd3);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h0F);
    err(1'b0, 0, 1'b1, 16'h0303, 7'd2, 1'b1);
    err(1'b0, 0, 1'b1, 16'h0303, 7'd2, 1'b1);
    check("R9", "below threshold", flg_prof, 0);
    err(1'b0, 0, 1'b1, 16'h0303, 7'd2, 1'b1);
    check("R9", "at threshold", flg_prof, 1);
    check("R8", "count three", prof_count, 3);
    // R7 profiling flag clear bit 3
    wr(2'd2, 8'h08);
    check("R7", "prof flag cleared", flg_prof, 0);
    err(1'b0, 0, 1'b1, 16'h0303, 7'd2, 1'b1);
    check("R9", "reset again", flg_prof, 1);
    wr(2'd0, 8'h01);
    @(negedge clk);
    check("R9", "disabled flag", flg_prof, 0);
    check("R9", "disabled count", prof_count, 0);

    // R10 counter load, R8 saturation
    wr(2'd0, 8'h05);
    wr(2'd1, 8'd250);
    wr(2'd3, 8'd77);
    check("R10", "load", prof_count, 77);
    wr(2'd3, 8'd254);
    err(1'b1, 16'h0404, 1'b1, 16'h0505, 7'd6, 1'b1);
    check("R8", "saturate", prof_count, 255);
    err(1'b0, 0, 1'b1, 16'h0505, 7'd6, 1'b1);
    check("R8", "hold max", prof_count, 255);

    // R12 control write takes effect for the next cycle only
    wr(2'd0, 8'h00);
    err(1'b0, 0, 1'b1, 16'h0606, 7'd8, 1'b1);
    check("R12", "disabled enable", err_event, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule